// File: doc/BRIEF.md
# Flash Read-Margin Control Unit

This block picks the read sense margin for two flash arrays, a program array and a data array. Each array has its own margin register with an enable bit and a level bit. When the enable bit is clear, the array reads with its default margin. When it is set, the level bit picks the low-level margin (0) or the high-level margin (1). Software sweeps an array with a stricter margin to find weak cells. A weak cell flips from 1 to 0 under the stricter margin, and the ECC decoder then flags it. This block turns those flags into an error interrupt or a bus-error trap.

Four guards sit on the write path:
- Writes to the program-array register need an unlock input.
- Only one array may have a non-default margin enabled at a time.
- Writes to either margin register are refused while an erase or program operation runs. Both arrays also fall back to default margins during that operation.
- After an accepted write that changes an effective margin, a settle timer holds `margin_ready` low for a parameterised number of cycles. The sense amplifiers need this time to adjust.

The double-bit trap comes out of reset disabled. While it is disabled, double-bit errors go to the interrupt instead of the trap. A read whose check bits are all zero is an erased location and raises nothing.

Top module: `flash_margin_ctrl`

## Requirements
- R1: After reset both margin registers read 0, the outputs `pf_margin_en`, `pf_margin_lvl`, `df_margin_en` and `df_margin_lvl` are 0, the error configuration register reads 0 (trap disabled), the status register reads 0, and `margin_ready` is 1.
- R2: The program-array margin register is at address 0 and the data-array register at address 1. In each, bit 0 is the enable and bit 1 is the level (0 = low margin, 1 = high margin). Both registers read back as written. An array's enable output equals its enable bit. Its level output equals enable AND level.
- R3: A write that sets the enable bit of one array while the other array's enable bit is set is rejected: the register keeps its value and the rejected flag is set.
- R4: A write to address 0 while `prot_unlock` is 0 is rejected and sets the rejected flag. Writes to address 1 need no unlock.
- R5: An accepted write that changes an array's effective margin code ({enable, enable AND level}) drives `margin_ready` low from the next cycle for exactly SETTLE_CYCLES cycles. Status bit 0 (address 3) reads 1 while the timer runs.
- R6: An accepted write that leaves the effective margin code unchanged does not restart the timer, and `margin_ready` stays 1.
- R7: While `flash_busy` is 1, all four margin outputs are 0 and writes to addresses 0 and 1 are rejected and set the rejected flag. The register contents are kept and come back to the outputs once `flash_busy` falls.
- R8: When `rd_valid` is 1 with `ecc_sbe` set and non-zero `rd_check`, `err_irq` pulses high for exactly one cycle, one cycle later.
- R9: Bit 0 of the error configuration register (address 2) enables the trap. A double-bit error (`ecc_dbe` with `rd_valid` and non-zero check bits) pulses `bus_trap` one cycle later when this bit is 1. It pulses `err_irq` instead when the bit is 0. The two outputs are never high together.
- R10: A valid read with `rd_check` all zero raises neither `err_irq` nor `bus_trap`, whatever the error inputs are. Without `rd_valid`, neither output is raised.
- R11: The rejected flag is status bit 1 (address 3). It is sticky and is cleared by writing address 3 with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| prot_unlock | input | 1 | Unlocks writes to the program-array margin register |
| flash_busy | input | 1 | Erase or program operation in progress |
| rd_valid | input | 1 | Array read result valid this cycle |
| ecc_sbe | input | 1 | Decoder reports a single-bit error |
| ecc_dbe | input | 1 | Decoder reports a double-bit error |
| rd_check | input | CHK_W | Check bits of the read word |
| pf_margin_en | output | 1 | Program array uses non-default margin |
| pf_margin_lvl | output | 1 | Program array margin level |
| df_margin_en | output | 1 | Data array uses non-default margin |
| df_margin_lvl | output | 1 | Data array margin level |
| margin_ready | output | 1 | Settling done; margin reads may proceed |
| err_irq | output | 1 | Error interrupt pulse |
| bus_trap | output | 1 | Bus-error trap pulse |

## Verification
If the interlock state were wrong, both enable outputs could be high at once, or a margin register could read back a value that should have been refused. Either shows in the cycle right after the offending write. A timer that restarts wrongly or loads the wrong count shows up as a `margin_ready` low window of the wrong length, measured edge by edge against SETTLE_CYCLES. Routing faults show on the cycle after `rd_valid`: a pulse on the wrong output, a pulse that lasts more than one cycle, or a pulse for an erased word.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  typedef struct packed {
    logic lvl;
    logic en;
  } margin_t;

  localparam margin_t MARGIN_DEFAULT = '{lvl: 1'b0, en: 1'b0};

  typedef enum logic [1:0] {
    SEL_PF     = 2'd0,
    SEL_DF     = 2'd1,
    SEL_ERRCFG = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  // Effective code driven to an array: level only counts when enabled.
  function automatic logic [1:0] eff_code(margin_t m);
    return {m.en, m.en & m.lvl};
  endfunction

  // A write that enables a margin on one array clashes with an enabled other array.
  function automatic logic clashes(margin_t incoming, margin_t other);
    return incoming.en & other.en;
  endfunction

endpackage

// File: rtl/fmc_margin_regs.sv
module fmc_margin_regs
  import fmc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_pf,
  input  logic    wr_df,
  input  margin_t wr_val,
  input  logic    unlock,
  input  logic    flash_busy,
  input  logic    clr_rej,
  output margin_t pf_q,
  output margin_t df_q,
  output logic    rej_q,
  output logic    margin_changed
);

  logic pf_ok, df_ok, pf_refused, df_refused;
  logic pf_changes, df_changes;

  assign pf_ok      = wr_pf && unlock && !flash_busy && !clashes(wr_val, df_q);
  assign df_ok      = wr_df && !flash_busy && !clashes(wr_val, pf_q);
  assign pf_refused = wr_pf && !pf_ok;
  assign df_refused = wr_df && !df_ok;

  assign pf_changes = pf_ok && (eff_code(wr_val) != eff_code(pf_q));
  assign df_changes = df_ok && (eff_code(wr_val) != eff_code(df_q));
  assign margin_changed = pf_changes || df_changes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q  <= MARGIN_DEFAULT;
      df_q  <= MARGIN_DEFAULT;
      rej_q <= 1'b0;
    end else begin
      if (pf_ok) pf_q <= wr_val;
      if (df_ok) df_q <= wr_val;
      if (pf_refused || df_refused) rej_q <= 1'b1;
      else if (clr_rej)             rej_q <= 1'b0;
    end
  end

  assert_single_margin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_q.en && df_q.en));

  assert_clash_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_df && wr_val.en && pf_q.en) |=> (rej_q && $stable(df_q)));

  assert_pf_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pf && !unlock) |=> ($stable(pf_q) && rej_q));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |=> ($stable(pf_q) && $stable(df_q)));

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rej && !wr_pf && !wr_df) |=> !rej_q);

endmodule

// File: rtl/fmc_settle_timer.sv
module fmc_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ready
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (restart)        remain <= CNT_W'(SETTLE_CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign ready = (remain == '0);

  assert_restart_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ready);

  assert_idle_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !restart) |=> ready);

endmodule

// File: rtl/fmc_ecc_route.sv
module fmc_ecc_route #(
  parameter int unsigned CHK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic             sbe,
  input  logic             dbe,
  input  logic [CHK_W-1:0] chk,
  input  logic             trap_en,
  output logic             irq,
  output logic             trap
);

  logic qualified, to_trap, to_irq;

  // Erased words carry all-zero check bits and are treated as clean.
  assign qualified = rd_valid && (chk != '0);
  assign to_trap   = qualified && dbe && trap_en;
  assign to_irq    = qualified && (sbe || (dbe && !trap_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      trap <= 1'b0;
    end else begin
      irq  <= to_irq && !to_trap;
      trap <= to_trap;
    end
  end

  assert_sbe_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (qualified && sbe && !dbe) |=> irq);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && trap));

  assert_no_trap_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_en |=> !trap);

  assert_erased_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk == '0 || !rd_valid) |=> (!irq && !trap));

endmodule

// File: rtl/flash_margin_ctrl.sv
module flash_margin_ctrl
  import fmc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CHK_W         = 8,
  parameter int unsigned SETTLE_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              prot_unlock,
  input  logic              flash_busy,
  input  logic              rd_valid,
  input  logic              ecc_sbe,
  input  logic              ecc_dbe,
  input  logic [CHK_W-1:0]  rd_check,
  output logic              pf_margin_en,
  output logic              pf_margin_lvl,
  output logic              df_margin_en,
  output logic              df_margin_lvl,
  output logic              margin_ready,
  output logic              err_irq,
  output logic              bus_trap
);

  localparam int unsigned PAD_W = DATA_W - 2;

  // Named internal events
  logic    sel_pf, sel_df, sel_errcfg, sel_status;
  logic    wr_pf, wr_df, wr_errcfg, wr_status;
  logic    clr_rej;
  logic    margin_changed;
  logic    rej_q, trap_en_q;
  margin_t wr_val, pf_q, df_q;
  logic [1:0] pf_eff, df_eff;
  logic    unused_wdata_hi;

  assign sel_pf     = (bus_addr == ADDR_W'(SEL_PF));
  assign sel_df     = (bus_addr == ADDR_W'(SEL_DF));
  assign sel_errcfg = (bus_addr == ADDR_W'(SEL_ERRCFG));
  assign sel_status = (bus_addr == ADDR_W'(SEL_STATUS));

  assign wr_pf     = bus_we && sel_pf;
  assign wr_df     = bus_we && sel_df;
  assign wr_errcfg = bus_we && sel_errcfg;
  assign wr_status = bus_we && sel_status;
  assign clr_rej   = wr_status && bus_wdata[1];

  assign wr_val          = '{lvl: bus_wdata[1], en: bus_wdata[0]};
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2];

  fmc_margin_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_pf          (wr_pf),
    .wr_df          (wr_df),
    .wr_val         (wr_val),
    .unlock         (prot_unlock),
    .flash_busy     (flash_busy),
    .clr_rej        (clr_rej),
    .pf_q           (pf_q),
    .df_q           (df_q),
    .rej_q          (rej_q),
    .margin_changed (margin_changed)
  );

  fmc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (margin_changed),
    .ready   (margin_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         trap_en_q <= 1'b0;
    else if (wr_errcfg) trap_en_q <= bus_wdata[0];
  end

  fmc_ecc_route #(.CHK_W(CHK_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .sbe      (ecc_sbe),
    .dbe      (ecc_dbe),
    .chk      (rd_check),
    .trap_en  (trap_en_q),
    .irq      (err_irq),
    .trap     (bus_trap)
  );

  // Erase/program forces default margins at the arrays.
  assign pf_eff = flash_busy ? 2'b00 : eff_code(pf_q);
  assign df_eff = flash_busy ? 2'b00 : eff_code(df_q);
  assign pf_margin_en  = pf_eff[1];
  assign pf_margin_lvl = pf_eff[0];
  assign df_margin_en  = df_eff[1];
  assign df_margin_lvl = df_eff[0];

  always_comb begin
    bus_rdata = '0;
    if (sel_pf)          bus_rdata = {PAD_W'(0), pf_q};
    else if (sel_df)     bus_rdata = {PAD_W'(0), df_q};
    else if (sel_errcfg) bus_rdata = {PAD_W'(0), 1'b0, trap_en_q};
    else if (sel_status) bus_rdata = {PAD_W'(0), rej_q, !margin_ready};
  end

  assert_busy_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |-> !(pf_margin_en || df_margin_en || pf_margin_lvl || df_margin_lvl));

  assert_lvl_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_margin_lvl && !pf_margin_en) && !(df_margin_lvl && !df_margin_en));

endmodule

// File: tb/test_flash_margin_ctrl.sv
module test_flash_margin_ctrl;

  localparam int SETTLE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        prot_unlock = 1'b0, flash_busy = 1'b0;
  logic        rd_valid = 1'b0, ecc_sbe = 1'b0, ecc_dbe = 1'b0;
  logic [7:0]  rd_check = '0;
  logic        pf_margin_en, pf_margin_lvl, df_margin_en, df_margin_lvl;
  logic        margin_ready, err_irq, bus_trap;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_margin_ctrl #(.SETTLE_CYCLES(SETTLE)) i_flash_margin_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prot_unlock(prot_unlock),
    .flash_busy(flash_busy), .rd_valid(rd_valid), .ecc_sbe(ecc_sbe),
    .ecc_dbe(ecc_dbe), .rd_check(rd_check), .pf_margin_en(pf_margin_en),
    .pf_margin_lvl(pf_margin_lvl), .df_margin_en(df_margin_en),
    .df_margin_lvl(df_margin_lvl), .margin_ready(margin_ready),
    .err_irq(err_irq), .bus_trap(bus_trap));

  // Vector: [9] sel df, [8:7] wdata {lvl,en}, [6] unlock, [5] busy,
  //         [4:3] expected pf reg, [2:1] expected df reg, [0] expected reject flag
  localparam logic [9:0] VEC [10] = '{
    10'b0_01_1_0_01_00_0,  // R2 pf enable low margin
    10'b1_01_0_0_01_00_1,  // R3 df enable clashes
    10'b1_10_0_0_01_10_0,  // R2 df level without enable accepted
    10'b0_11_0_0_01_10_1,  // R4 locked pf write
    10'b0_11_1_0_11_10_0,  // R4 unlocked pf write
    10'b0_00_1_1_11_10_1,  // R7 write during busy
    10'b0_00_1_0_00_10_0,  // R2 pf back to default
    10'b1_11_0_0_00_11_0,  // R4 df needs no unlock
    10'b0_01_1_0_00_11_1,  // R3 pf enable clashes
    10'b1_01_0_1_00_11_1   // R7 df write during busy
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic unl, logic busy);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; prot_unlock = unl; flash_busy = busy;
    @(negedge clk);
    bus_we = 1'b0; prot_unlock = 1'b0; flash_busy = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && !margin_ready; k++) @(negedge clk);
  endtask

  task automatic ecc(logic v, logic s, logic db, logic [7:0] c, logic exp_irq,
                     logic exp_trap, string req);
    @(negedge clk);
    rd_valid = v; ecc_sbe = s; ecc_dbe = db; rd_check = c;
    @(negedge clk);
    rd_valid = 1'b0; ecc_sbe = 1'b0; ecc_dbe = 1'b0; rd_check = '0;
    check(req, {30'd0, err_irq, bus_trap}, {30'd0, exp_irq, exp_trap});
    @(negedge clk);
    check({req, " pulse ends"}, {30'd0, err_irq, bus_trap}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d); check("R1 pf reg", d, 0);
    rd(4'd1, d); check("R1 df reg", d, 0);
    rd(4'd2, d); check("R1 errcfg", d, 0);
    rd(4'd3, d); check("R1 status", d, 0);
    check("R1 outputs", {27'd0, pf_margin_en, pf_margin_lvl, df_margin_en,
          df_margin_lvl, margin_ready}, 32'd1);

    // Table of register write vectors
    foreach (VEC[i]) begin
      wr({3'd0, VEC[i][9]}, {30'd0, VEC[i][8:7]}, VEC[i][6], VEC[i][5]);
      rd(4'd0, d); check($sformatf("vec%0d R2 pf", i), d, {30'd0, VEC[i][4:3]});
      rd(4'd1, d); check($sformatf("vec%0d R2 df", i), d, {30'd0, VEC[i][2:1]});
      rd(4'd3, d); check($sformatf("vec%0d R11 reject", i), {31'd0, d[1]},
                         {31'd0, VEC[i][0]});
      wr(4'd3, 32'h2, 1'b0, 1'b0);
    end
    rd(4'd3, d); check("R11 reject cleared", {31'd0, d[1]}, 32'd0);

    // Effective outputs: df = {lvl=1,en=1}
    wait_idle();
    check("R2 df effective high", {30'd0, df_margin_en, df_margin_lvl}, 32'd3);
    check("R2 pf effective default", {30'd0, pf_margin_en, pf_margin_lvl}, 32'd0);

    // R5 settle length after changing effective margin
    wr(4'd1, 32'h1, 1'b0, 1'b0);
    rd(4'd3, d); check("R5 status busy", {31'd0, d[0]}, 32'd1);
    check("R2 df effective low", {30'd0, df_margin_en, df_margin_lvl}, 32'd2);
    lows = 0;
    while (!margin_ready && lows < 50) begin lows++; @(negedge clk); end
    check("R5 settle cycles", lows, SETTLE);
    rd(4'd3, d); check("R5 status idle", {31'd0, d[0]}, 32'd0);

    // R6 same effective margin does not restart
    wr(4'd1, 32'h1, 1'b0, 1'b0);
    check("R6 rewrite same", {31'd0, margin_ready}, 32'd1);
    wr(4'd1, 32'h2, 1'b0, 1'b0);   // enable off -> change
    check("R5 disable restarts", {31'd0, margin_ready}, 32'd0);
    wait_idle();
    wr(4'd1, 32'h0, 1'b0, 1'b0);   // level differs, still disabled
    check("R6 disabled level change", {31'd0, margin_ready}, 32'd1);
    check("R2 level masked", {30'd0, df_margin_en, df_margin_lvl}, 32'd0);

    // R7 busy forces defaults then restores
    wr(4'd1, 32'h3, 1'b0, 1'b0);
    @(negedge clk); flash_busy = 1'b1; #1;
    check("R7 forced default", {30'd0, df_margin_en, df_margin_lvl}, 32'd0);
    @(negedge clk); flash_busy = 1'b0; #1;
    check("R7 restored", {30'd0, df_margin_en, df_margin_lvl}, 32'd3);

    // ECC routing
    ecc(1'b1, 1'b1, 1'b0, 8'h5A, 1'b1, 1'b0, "R8 sbe irq");
    ecc(1'b1, 1'b0, 1'b1, 8'h01, 1'b1, 1'b0, "R9 dbe redirected");
    wr(4'd2, 32'h1, 1'b0, 1'b0);
    rd(4'd2, d); check("R9 errcfg readback", d, 32'd1);
    ecc(1'b1, 1'b0, 1'b1, 8'h80, 1'b0, 1'b1, "R9 dbe trap");
    ecc(1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R10 erased word");
    ecc(1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, "R10 no valid");
    wr(4'd2, 32'h0, 1'b0, 1'b0);
    ecc(1'b1, 1'b0, 1'b1, 8'h10, 1'b1, 1'b0, "R9 trap off again");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule